// File: doc/BRIEF.md
# Depth-Balanced Splitter Fan-Out Tree

This block models the fan-out network of a logic family in which every gate output may drive only one load. A single source gate, a three-input majority cell with one input tied to a constant, forms the AND (or, by parameter, the OR) of two operand bits. Its result is spread to `N_OUT` destinations through levels of one-to-two splitter cells. Wherever a branch of the tree would be shallower than the others, a one-stage buffer cell fills the gap. Every destination therefore sees the value after the same number of stages.

Each stage is a register that loads only when its phase enable is high. The source is stage 0, and tree level r is stage r. Stage r listens to phase enable bit `r mod 4`. The four phase enables come from the surrounding pipeline and normally rotate one bit per clock. A valid flag travels beside the data through the same phase-gated stages and leaves as one common output valid.

Top module: `fo_balanced_fanout`

## Requirements
- R1: While `rst_n` is low, and after its release until the first output update, `out_data` is all zeros and `out_valid` is 0.
- R2: With `SRC_KIND` = AND (encoding 0), every output lane carries `in_a & in_b`, which is the majority of the operands and a constant 0.
- R3: With `SRC_KIND` = OR (encoding 1), every output lane carries `in_a | in_b`, which is the majority of the operands and a constant 1.
- R4: Bit i of `phase_en` is phase i. The tree depth is D = ceil(log2 `N_OUT`). Outputs update only on clock edges where `phase_en[D mod 4]` is high. When the phases rotate one per clock, the value captured on a phase-0 edge appears D edges later, and `out_valid` equals the `in_valid` captured with it.
- R5: All `N_OUT` lanes hold the same value at all times after reset, so they change on the same edge.
- R6: At most one `phase_en` bit is high at a time. On edges where `phase_en[D mod 4]` is low, including stretches where all enables are low, `out_data` and `out_valid` keep their values.
- R7: `in_a`, `in_b` and `in_valid` are sampled only on edges where `phase_en[0]` is high. Changes at any other time have no effect on the outputs.
- R8: A slot captured with `in_valid` = 0 produces `out_valid` = 0. Its logic value still travels to `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_en | input | N_PHASE | One-hot stage enables shared with the pipeline; bit i enables stages whose index mod 4 is i |
| in_a | input | 1 | First operand of the source gate |
| in_b | input | 1 | Second operand of the source gate |
| in_valid | input | 1 | Marks the operand pair as a real item |
| out_data | output | N_OUT | Balanced copies of the source result |
| out_valid | output | 1 | Common valid for all output lanes |

## Verification
The hardest condition to reach from the ports is an operand change that falls between phase-0 edges while the tree is partly filled. It matters most when that change lands inside a stall, where all phase enables are low and nothing moves. The stimulus deliberately inverts or randomises the operands and the valid flag on every non-capture cycle. It also inserts stall cycles between phase 1 and phase 2 of a slot. Only the value held at the phase-0 edge may appear at the outputs, and the outputs must not move during the stall. Two instances run on the same stimulus: an AND source with five lanes and an OR source with seven lanes. Both are three levels deep, and both contain padded branches.

// File: rtl/fo_tree_pkg.sv
package fo_tree_pkg;

   localparam int unsigned FO_PHASES = 4;

   typedef enum logic {
      SRC_AND = 1'b0,
      SRC_OR  = 1'b1
   } fo_src_e;

   // three-input majority: output follows at least two of the inputs
   function automatic logic fo_maj3(input logic x, input logic y, input logic z);
      return (x & y) | (y & z) | (x & z);
   endfunction

   // number of splitter levels: smallest l with 2**l >= n
   function automatic int unsigned fo_levels(input int unsigned n);
      int unsigned l;
      l = 0;
      for (int i = 0; i < 31; i++) begin
         if ((32'd1 << i) < n) l = i + 1;
      end
      return l;
   endfunction

   // lanes present at level lvl of a depth-d tree feeding n leaves
   function automatic int unsigned fo_lanes(input int unsigned n,
                                            input int unsigned d,
                                            input int unsigned lvl);
      int unsigned sh;
      sh = d - lvl;
      return (n + (32'd1 << sh) - 1) >> sh;
   endfunction

endpackage

// File: rtl/fo_maj_src.sv
module fo_maj_src
   import fo_tree_pkg::*;
#(
   parameter fo_src_e SRC_KIND = SRC_AND
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic a,
   input  logic b,
   output logic q
);
   localparam logic TIE = (SRC_KIND == SRC_OR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= fo_maj3(a, b, TIE);
   end

   // equal operands outvote the tied input whatever its value
   AST_MAJ_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (a == b)) |=> (q == $past(a)));   // R2

endmodule

// File: rtl/fo_split2.sv
module fo_split2 (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q_a,
   output logic q_b
);
   // one splitter cell: one stage, two independent loads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_a <= 1'b0;
         q_b <= 1'b0;
      end else if (en) begin
         q_a <= d;
         q_b <= d;
      end
   end
endmodule

// File: rtl/fo_buf1.sv
module fo_buf1 (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);
   // balancing buffer: one stage, single load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/fo_balanced_fanout.sv
module fo_balanced_fanout
   import fo_tree_pkg::*;
#(
   parameter int unsigned N_OUT    = 5,
   parameter fo_src_e     SRC_KIND = SRC_AND,
   parameter int unsigned N_PHASE  = FO_PHASES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_PHASE-1:0] phase_en,
   input  logic               in_a,
   input  logic               in_b,
   input  logic               in_valid,
   output logic [N_OUT-1:0]   out_data,
   output logic               out_valid
);
   localparam int unsigned DEPTH  = fo_levels(N_OUT);
   localparam int unsigned PH_OUT = DEPTH % N_PHASE;

   if (N_OUT < 2) begin : g_bad_nout
      $error("fo_balanced_fanout: N_OUT must be at least 2");
   end
   if (N_OUT > 4096) begin : g_big_nout
      $error("fo_balanced_fanout: N_OUT too large for an unrolled tree");
   end
   if (N_PHASE != FO_PHASES) begin : g_bad_phase
      $error("fo_balanced_fanout: phase count must be four");
   end

   // stage 0: majority source gate and its valid flag
   logic src_q;
   logic src_vld;

   fo_maj_src #(.SRC_KIND(SRC_KIND)) u_src (
      .clk(clk), .rst_n(rst_n), .en(phase_en[0]),
      .a(in_a), .b(in_b), .q(src_q)
   );

   fo_buf1 u_src_vld (
      .clk(clk), .rst_n(rst_n), .en(phase_en[0]),
      .d(in_valid), .q(src_vld)
   );

   // stages 1..DEPTH: splitter levels, shallow branches padded with buffers
   for (genvar lvl = 1; lvl <= DEPTH; lvl++) begin : g_lvl
      localparam int unsigned CNT  = fo_lanes(N_OUT, DEPTH, lvl);
      localparam int unsigned PCNT = fo_lanes(N_OUT, DEPTH, lvl - 1);
      localparam int unsigned PH   = lvl % N_PHASE;

      logic [CNT-1:0]  lane;
      logic [PCNT-1:0] up;
      logic            vld;
      logic            vld_up;

      if (lvl == 1) begin : g_first
         assign up     = src_q;
         assign vld_up = src_vld;
      end else begin : g_next
         assign up     = g_lvl[lvl-1].lane;
         assign vld_up = g_lvl[lvl-1].vld;
      end

      for (genvar p = 0; p < PCNT; p++) begin : g_node
         if (2 * p + 1 < CNT) begin : g_split
            fo_split2 u_spl (
               .clk(clk), .rst_n(rst_n), .en(phase_en[PH]), .d(up[p]),
               .q_a(lane[2*p]), .q_b(lane[2*p+1])
            );
         end else begin : g_pad
            fo_buf1 u_pad (
               .clk(clk), .rst_n(rst_n), .en(phase_en[PH]), .d(up[p]),
               .q(lane[2*p])
            );
         end
      end

      fo_buf1 u_vld (
         .clk(clk), .rst_n(rst_n), .en(phase_en[PH]),
         .d(vld_up), .q(vld)
      );
   end

   assign out_data  = g_lvl[DEPTH].lane;
   assign out_valid = g_lvl[DEPTH].vld;

   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_en));   // R6

   AST_LANES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      ((&out_data) || (~|out_data)));   // R5

   AST_HOLD_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_en[PH_OUT] |=> ($stable(out_data) && $stable(out_valid)));   // R6

   AST_VALID_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(phase_en[PH_OUT]));   // R4

endmodule

// File: tb/test_fo_balanced_fanout.sv
module test_fo_balanced_fanout;
   import fo_tree_pkg::*;

   localparam int N_AND = 5;
   localparam int N_OR  = 7;
   localparam int OUTPH = 3;  // both trees are 3 levels deep: 3 mod 4

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n;
   logic [3:0]       phase_en;
   logic             in_a, in_b, in_valid;
   logic [N_AND-1:0] and_data;
   logic             and_vld;
   logic [N_OR-1:0]  or_data;
   logic             or_vld;

   fo_balanced_fanout #(.N_OUT(N_AND), .SRC_KIND(SRC_AND)) i_fo_balanced_fanout (
      .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .in_a(in_a), .in_b(in_b),
      .in_valid(in_valid), .out_data(and_data), .out_valid(and_vld)
   );

   fo_balanced_fanout #(.N_OUT(N_OR), .SRC_KIND(SRC_OR)) i_fo_balanced_fanout_or (
      .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .in_a(in_a), .in_b(in_b),
      .in_valid(in_valid), .out_data(or_data), .out_valid(or_vld)
   );

   typedef struct {
      bit    v;
      bit    a;
      bit    b;
      string tag_and;
      string tag_or;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    out_edge = 1'b0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   logic [N_AND-1:0] prev_and;
   logic [N_OR-1:0]  prev_or;
   logic             prev_av, prev_ov;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) out_edge <= phase_en[OUTPH];

   // monitor: pops one expected item per output-phase edge
   always @(negedge clk) begin
      if (mon_on) begin
         check((&and_data) || (~|and_data), "R5", "AND lanes differ", 32'(and_data), 0);
         check((&or_data) || (~|or_data), "R5", "OR lanes differ", 32'(or_data), 0);
         if (out_edge) begin
            if (q.size() == 0) begin
               check(1'b0, "R4", "output update with no item", 0, 1);
            end else begin
               item_t it;
               logic ea, eo;
               it = q.pop_front();
               ea = it.a & it.b;
               eo = it.a | it.b;
               check(and_data == {N_AND{ea}}, it.tag_and, "AND lanes",
                     32'(and_data), 32'({N_AND{ea}}));
               check(or_data == {N_OR{eo}}, it.tag_or, "OR lanes",
                     32'(or_data), 32'({N_OR{eo}}));
               check(and_vld == it.v, it.v ? "R4" : "R8", "AND valid",
                     32'(and_vld), 32'(it.v));
               check(or_vld == it.v, it.v ? "R4" : "R8", "OR valid",
                     32'(or_vld), 32'(it.v));
            end
         end else begin
            check(and_data == prev_and && and_vld == prev_av, "R6", "AND moved off phase",
                  32'({and_vld, and_data}), 32'({prev_av, prev_and}));
            check(or_data == prev_or && or_vld == prev_ov, "R6", "OR moved off phase",
                  32'({or_vld, or_data}), 32'({prev_ov, prev_or}));
         end
         prev_and = and_data;
         prev_or  = or_data;
         prev_av  = and_vld;
         prev_ov  = or_vld;
      end
   end

   // driver: one slot is a phase-0 capture followed by phases 1..3
   task automatic slot(input bit a, input bit b, input bit v,
                       input int stall, input bit noisy);
      item_t it;
      @(negedge clk);
      phase_en = 4'b0001;
      in_a = a; in_b = b; in_valid = v;
      it.v = v; it.a = a; it.b = b;
      it.tag_and = (noisy || stall > 0) ? "R7" : "R2";
      it.tag_or  = (noisy || stall > 0) ? "R7" : "R3";
      q.push_back(it);
      for (int p = 1; p < 4; p++) begin
         @(negedge clk);
         if (p == 2) begin
            for (int s = 0; s < stall; s++) begin
               phase_en = 4'b0000;
               in_a = 1'($urandom % 2); in_b = 1'($urandom % 2);
               in_valid = 1'($urandom % 2);
               @(negedge clk);
            end
         end
         phase_en = 4'b0001 << p;
         if (noisy) begin
            in_a = ~a; in_b = ~b; in_valid = ~v;
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; phase_en = 4'b0000;
      in_a = 1'b1; in_b = 1'b1; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check(and_data == '0 && !and_vld, "R1", "AND during reset", 32'({and_vld, and_data}), 0);
      check(or_data == '0 && !or_vld, "R1", "OR during reset", 32'({or_vld, or_data}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(and_data == '0 && !and_vld, "R1", "AND after release", 32'({and_vld, and_data}), 0);
      check(or_data == '0 && !or_vld, "R1", "OR after release", 32'({or_vld, or_data}), 0);
      prev_and = and_data; prev_or = or_data; prev_av = and_vld; prev_ov = or_vld;
      mon_on = 1'b1;

      // every operand pair, clean
      slot(0, 0, 1, 0, 0);
      slot(0, 1, 1, 0, 0);
      slot(1, 0, 1, 0, 0);
      slot(1, 1, 1, 0, 0);
      // bubbles (R8)
      slot(1, 1, 0, 0, 0);
      slot(0, 1, 0, 0, 0);
      // operands change between captures (R7)
      slot(0, 0, 1, 0, 1);
      slot(1, 1, 0, 0, 1);
      slot(0, 1, 1, 0, 1);
      // stalls with all enables low (R6, R7)
      slot(1, 1, 1, 4, 0);
      slot(0, 1, 1, 2, 1);
      // back-to-back random slots
      for (int i = 0; i < 40; i++) begin
         slot(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
              int'($urandom % 3), 1'($urandom % 2));
      end

      @(negedge clk);
      phase_en = 4'b0000;
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R4", "items left unproduced", 32'(q.size()), 0);
      mon_on = 1'b0;
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule